// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block is the synchronous read front end of a word-wide memory. It captures a start address with an active-low load strobe. It then steps a five-bit window counter on rising clock edges while an active-low advance strobe and an active-low output enable are both asserted. Each step fetches one 16-bit word from an internal register-file array into a registered output word. The counter wraps inside the 32-word window that contains the start address, so a burst never leaves its aligned block. An active-low marker shows the final word of the window.

Taking both strobes high suspends the burst. The output is released, but the held word is kept. Lowering only the output enable drives that held word again. Lowering both strobes resumes stepping. The tri-state output is modelled as a valid flag together with a data bus that is forced to zero whenever the flag is low. An asynchronous active-low reset aborts any burst and returns the controller to idle. The array is filled through a plain write port that the user drives before reading.

The controller has three states. `ST_IDLE` is the state after reset, with no burst loaded. `ST_RUN` means a burst is loaded and the output word is live. `ST_SUSP` means a burst is parked with both strobes high. The transitions are as follows. *start*: any state goes to `ST_RUN` on an edge with the load strobe low. *park*: `ST_RUN` goes to `ST_SUSP` on an edge with both strobes high and no load. *wake*: `ST_SUSP` goes to `ST_RUN` on an edge with either strobe low. *abort*: reset sends any state to `ST_IDLE`. In every other case the state holds.

Top module: `bsq_burst_reader`

## Requirements
- R1: An edge with `ld_n` low captures `addr`, clears the window counter to 0 and loads the word at `addr` into the output register. When `oe_n` is low after that edge, `dout` shows that word with `dvalid` 1.
- R2: In a loaded state, an edge with `adv_n` and `oe_n` both low (and `ld_n` high) increments the counter, and the next window word appears after that edge.
- R3: With `adv_n` and `oe_n` both high, `dvalid` is 0 and `dout` is 0, and the held word is not changed.
- R4: With `oe_n` low and `adv_n` high, the held word is driven, and it stays unchanged over any number of such edges.
- R5: With `adv_n` low and `oe_n` high, the counter does not advance, so the next read shows the same word.
- R6: `last_n` is 0 exactly when `dvalid` is 1 and the counter is 31 (binary 11111), and 1 otherwise.
- R7: Advancing past counter 31 wraps the counter to 0, and the start word is output again.
- R8: The word address is the start address with its low five bits replaced by (start low bits + counter) mod 32. An unaligned start therefore wraps inside its aligned 32-word block.
- R9: When `ld_n` and `adv_n` are low on the same edge, the load wins and the new start word is shown without a step.
- R10: `oe_n` high forces `dvalid` to 0 and `dout` to 0 in every state.
- R11: `rst_n` low at once forces `dvalid` 0 and `dout` 0, and ignores `ld_n` while it is asserted. After release the block is idle, and advancing shows nothing until a load.
- R12: An edge with `init_we` high writes `init_data` at `init_addr`, and a later load of that address returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Load start address, active low |
| adv_n | input | 1 | Advance strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Burst start address |
| init_we | input | 1 | Array write enable |
| init_addr | input | ADDR_W | Array write address |
| init_data | input | DATA_W | Array write data |
| dout | output | DATA_W | Output word, zero when not valid |
| dvalid | output | 1 | Output driven (models the bus leaving high impedance) |
| last_n | output | 1 | Last word of window, active low |

## Verification
The bench starts an unaligned burst at 0x7D and runs it past the top of its block. A sequencer that carried into the upper address bits would fetch from 0x80 and beyond instead of 0x60. It then steps the full window to check that the end marker falls only on the 32nd word and that the next step shows the start word again. An off-by-one counter would move the marker, or would skip or repeat a word.

The bench also mixes the strobes. It suspends the burst, re-presents the held word, and holds advance low with the output disabled. A design that stepped on `adv_n` alone, or that refetched on resume, would show a different word. A load issued together with an advance checks the priority rule. A reset asserted mid-burst with a load held low checks that the block comes back idle and shows nothing.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int BSQ_WIN_BITS = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2
    } bsq_state_e;
endpackage

// File: rtl/bsq_array.sv
module bsq_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
    parameter int ADDR_W = 8,
    parameter int WIN_W  = bsq_pkg::BSQ_WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [WIN_W-1:0]  cnt,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam int LOW_W = (ADDR_W < WIN_W) ? ADDR_W : WIN_W;

    logic [ADDR_W-1:0] base_q;
    logic [WIN_W-1:0]  cnt_q;
    logic [WIN_W-1:0]  cnt_nxt;
    logic [LOW_W-1:0]  low_sum;
    logic [ADDR_W-1:0] step_addr;

    assign cnt_nxt = cnt_q + 1'b1;
    assign low_sum = base_q[LOW_W-1:0] + cnt_nxt[LOW_W-1:0];

    generate
        if (ADDR_W > WIN_W) begin : g_split
            assign step_addr = {base_q[ADDR_W-1:WIN_W], low_sum};
        end else begin : g_whole
            assign step_addr = low_sum;
        end
    endgenerate

    assign fetch_addr = load ? start_addr : step_addr;
    assign cnt        = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= start_addr;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_nxt;
        end
    end

    // R1
    load_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));

    // R7
    window_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (&cnt_q)) |=> (cnt_q == '0));

    // R5
    idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt_q));

    // R8
    stays_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ADDR_W <= WIN_W) || (fetch_addr[ADDR_W-1:LOW_W] == base_q[ADDR_W-1:LOW_W]) || load);
endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
    import bsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_n,
    input  logic       adv_n,
    input  logic       oe_n,
    output logic       load,
    output logic       step,
    output logic       drive,
    output bsq_state_e state
);
    bsq_state_e state_q;
    bsq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ld_n) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!ld_n)               state_d = ST_RUN;
                else if (adv_n && oe_n)  state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (!ld_n || !adv_n || !oe_n) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load  = !ld_n;
        step  = 1'b0;
        drive = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step  = 1'b0;
                drive = 1'b0;
            end
            ST_RUN, ST_SUSP: begin
                step  = ld_n && !adv_n && !oe_n;
                drive = rst_n && !oe_n;
            end
            default: begin
                step  = 1'b0;
                drive = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    // R11
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!drive && !step));

    // R9
    load_beats_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !step);

    // R3
    park_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ld_n && adv_n && oe_n) |=> (state_q == ST_SUSP));
endmodule

// File: rtl/bsq_burst_reader.sv
module bsq_burst_reader
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              adv_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [DATA_W-1:0] init_data,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid,
    output logic              last_n
);
    localparam int WIN_W = BSQ_WIN_BITS;

    logic              load;
    logic              step;
    logic              drive;
    bsq_state_e        state;
    logic [WIN_W-1:0]  cnt;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] word_q;

    bsq_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_n  (ld_n),
        .adv_n (adv_n),
        .oe_n  (oe_n),
        .load  (load),
        .step  (step),
        .drive (drive),
        .state (state)
    );

    bsq_addr_gen #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .start_addr (addr),
        .cnt        (cnt),
        .fetch_addr (fetch_addr)
    );

    bsq_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (init_we),
        .wr_addr (init_addr),
        .wr_data (init_data),
        .rd_addr (fetch_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            word_q <= '0;
        else if (load || step) word_q <= rd_data;
    end

    assign dvalid = drive;
    assign dout   = drive ? word_q : '0;
    assign last_n = !(drive && (&cnt));

    // R10
    oe_gates_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dvalid && dout == '0));

    // R6
    last_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_n |-> dvalid);

    // R4
    held_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(word_q));

    // R11
    state_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);
endmodule

// File: tb/tb_bsq_burst_reader.sv
module tb_bsq_burst_reader;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NVEC   = 13;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ld_n, adv_n, oe_n;
    logic [ADDR_W-1:0] addr;
    logic              init_we;
    logic [ADDR_W-1:0] init_addr;
    logic [DATA_W-1:0] init_data;
    logic [DATA_W-1:0] dout;
    logic              dvalid;
    logic              last_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bsq_burst_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .adv_n(adv_n), .oe_n(oe_n),
        .addr(addr), .init_we(init_we), .init_addr(init_addr),
        .init_data(init_data), .dout(dout), .dvalid(dvalid), .last_n(last_n)
    );

    function automatic logic [15:0] pat(input logic [7:0] a);
        return (16'(a) * 16'h0123) ^ 16'h5A5A;
    endfunction

    // {ld_n, adv_n, oe_n, addr[7:0], exp_valid, exp_addr[7:0], exp_last_n}
    localparam logic [20:0] VT [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 8'h40, 1'b1, 8'h40, 1'b1},  // R1 load
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h41, 1'b1},  // R2 step
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h42, 1'b1},  // R2 step
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b1},  // R3 suspend
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h42, 1'b1},  // R4 replay held
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h42, 1'b1},  // R4 still held
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b1},  // R5/R10 adv only
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h42, 1'b1},  // R5 no step taken
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h43, 1'b1},  // R2 resume
        {1'b0, 1'b0, 1'b0, 8'h7D, 1'b1, 8'h7D, 1'b1},  // R9 load wins
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h7E, 1'b1},  // R2
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h7F, 1'b1},  // R2
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h60, 1'b1}   // R8 block wrap
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge, inputs unchanged
    task automatic cycle(input logic l, input logic a, input logic o, input logic [7:0] ad);
        ld_n = l; adv_n = a; oe_n = o; addr = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_word(input string req, input logic v, input logic [7:0] ea, input logic el);
        check({req, " dvalid"}, 16'(dvalid), 16'(v));
        check({req, " dout"}, dout, v ? pat(ea) : 16'h0000);
        check({req, " last_n"}, 16'(last_n), 16'(el));
    endtask

    initial begin
        rst_n = 1'b0; ld_n = 1'b1; adv_n = 1'b1; oe_n = 1'b0; addr = '0;
        init_we = 1'b0; init_addr = '0; init_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state, output enabled but nothing loaded
        check("R11 reset dvalid", 16'(dvalid), 16'h0);
        check("R11 reset dout", dout, 16'h0);
        check("R11 reset last_n", 16'(last_n), 16'h1);
        oe_n = 1'b1;
        for (int i = 0; i < 256; i++) begin
            init_we = 1'b1; init_addr = 8'(i); init_data = pat(8'(i));
            @(posedge clk);
            @(negedge clk);
        end
        init_we = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            cycle(VT[i][20], VT[i][19], VT[i][18], VT[i][17:10]);
            expect_word($sformatf("R1-vec%0d", i), VT[i][9], VT[i][8:1], VT[i][0]);
        end

        // R6 R7 R8: continue from counter 3 up to 31, then wrap
        for (int k = 4; k <= 31; k++) begin
            logic [7:0] ea;
            ea = {3'b011, 5'(5'h1D + 5'(k))};
            cycle(1'b1, 1'b0, 1'b0, 8'h00);
            expect_word("R6 window", 1'b1, ea, (k == 31) ? 1'b0 : 1'b1);
        end
        // R6 marker hidden when output disabled at counter 31
        cycle(1'b1, 1'b1, 1'b1, 8'h00);
        check("R6 last_n gated", 16'(last_n), 16'h1);
        cycle(1'b1, 1'b1, 1'b0, 8'h00);
        expect_word("R6 held last", 1'b1, 8'h7C, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_word("R7 wrap to start", 1'b1, 8'h7D, 1'b1);

        // R12 array write then read back
        init_we = 1'b1; init_addr = 8'h10; init_data = 16'hBEEF;
        cycle(1'b1, 1'b1, 1'b1, 8'h00);
        init_we = 1'b0;
        cycle(1'b0, 1'b1, 1'b0, 8'h10);
        check("R12 written word", dout, 16'hBEEF);

        // R11 asynchronous reset mid-burst
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b0;
        #1;
        check("R11 immediate dvalid", 16'(dvalid), 16'h0);
        check("R11 immediate dout", dout, 16'h0);
        ld_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0; addr = 8'h20;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R11 load ignored in reset", 16'(dvalid), 16'h0);
        rst_n = 1'b1;
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        check("R11 idle after release dvalid", 16'(dvalid), 16'h0);
        check("R11 idle after release dout", dout, 16'h0);
        cycle(1'b0, 1'b1, 1'b0, 8'h20);
        expect_word("R1 load after reset", 1'b1, 8'h20, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule